// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block fetches one complete raw page from one of several NAND devices that share a bus and returns it as a byte stream. A single-cycle start pulse captures a 24-bit page number, a transfer length and a chip index. The sequencer then enables the chosen device, waits a short settling time and waits for the device to report ready. It writes the page-read opcode, two zero column bytes, three row bytes and the confirm opcode. It waits for the device to become ready again and then clocks out the requested number of bytes.

Each write and read strobe has a low phase and a high phase whose lengths are set by parameters. An idle cycle separates consecutive strobes so that the bus value and the CLE/ALE levels settle before the next falling edge. A zero length selects a default that covers a 4 KiB data area plus its 218-byte spare area. The default is a parameter so that it can suit the attached part. If the ready line stays low longer than a timeout during either wait, the read is abandoned and flagged.

Top module: `nand_page_reader`

## Requirements
- R1: After reset all chip enables are high, WE# and RE# are high, CLE, ALE, `dout_valid`, `done` and `err` are low.
- R2: After a start only the chip enable named by `chip` is low, and it holds steady until the read ends. The first WE# fall happens only after `PAUSE_CYC` settling cycles and after R/B# has been seen high.
- R3: The device receives exactly seven bus writes, each latched on the WE# rising edge, in this order: CLE with 0x00; ALE with 0x00; ALE with 0x00; ALE with page[7:0]; ALE with page[15:8]; ALE with page[23:16]; CLE with 0x30.
- R4: Every WE# and RE# low phase lasts exactly `LO_CYC` clock cycles. Between two strobes the line stays high for at least `HI_CYC` cycles.
- R5: After the 0x30 write, RE# does not fall until `PAUSE_CYC` cycles have passed and R/B# is high again.
- R6: A read of N bytes gives exactly N RE# strobes. For each strobe `dout_valid` is high for one cycle, and `dout` carries the bus byte sampled in the last low cycle of that strobe.
- R7: A `byte_count` of zero transfers `DEF_BYTES` bytes (4314 by default).
- R8: After the last byte every chip enable is high and `done` pulses for one cycle with `err` low.
- R9: If R/B# stays low for `TMO_CYC` cycles in either wait, the read stops with no further strobes. The chip enables go high and `done` pulses with `err` high.
- R10: A start pulse that arrives while a read is in progress is ignored. No second command sequence follows and the byte count is unchanged.
- R11: CLE and ALE are never high together. The bus is driven (`io_oe`) only while a command or address byte is being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to read a page |
| page | input | 24 | Page (row) number |
| byte_count | input | CNT_W | Bytes to read; 0 selects DEF_BYTES |
| chip | input | CHIP_W | Index of the device to read |
| ce_n | output | NCHIP | Active-low chip enables, one per device |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| io_out | output | 8 | Byte driven onto the bus |
| io_oe | output | 1 | Bus output enable |
| io_in | input | 8 | Byte read from the bus |
| rb_n | input | 1 | Ready (high) / busy (low) from the device |
| dout | output | 8 | Byte read from the page |
| dout_valid | output | 1 | Qualifies `dout` for one cycle |
| done | output | 1 | One-cycle end-of-read pulse |
| err | output | 1 | High with `done` when the read timed out |

## Verification
Each read byte appears on `dout` one cycle after the last low cycle of its RE# strobe, which is the cycle in which RE# goes high. The bench model changes the bus byte only on the negative edge after an RE# rise and compares each `dout` on the negative edge where `dout_valid` is high. `done` and the released chip enables appear together, one cycle after the last strobe's high phase. The bench waits for `done` on negative edges and reads `err` and `ce_n` in that same cycle. R/B# goes through a two-stage synchronizer, so ready is seen two cycles late. For that reason the model's busy windows and the timeout case keep margins of several cycles, and strobe widths are counted in whole cycles on negative edges.

// File: rtl/nprd_pkg.sv
package nprd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PAUSE,
    S_WAIT,
    S_WR,
    S_RD,
    S_FIN
  } nprd_state_t;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_CONFIRM = 8'h30;
  localparam logic [2:0] LAST_STEP  = 3'd6;

  // steps 0 and 6 are commands, 1..5 are address cycles
  function automatic logic step_is_cmd(input logic [2:0] s);
    return (s == 3'd0) || (s == LAST_STEP);
  endfunction

  function automatic logic [7:0] step_byte(input logic [2:0] s, input logic [23:0] pg);
    case (s)
      3'd0:    return OP_READ;
      3'd3:    return pg[7:0];
      3'd4:    return pg[15:8];
      3'd5:    return pg[23:16];
      3'd6:    return OP_CONFIRM;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] eff_len(input logic [31:0] req, input logic [31:0] dflt);
    return (req == 32'd0) ? dflt : req;
  endfunction

endpackage

// File: rtl/nprd_strobe.sv
module nprd_strobe #(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic strobe_n,
  output logic sample,
  output logic fin
);
  localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

  logic          active;
  logic          low;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      low    <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (en) begin
        active <= 1'b1;
        low    <= 1'b1;
        cnt    <= CW'(LO_CYC - 1);
      end
    end else if (cnt == '0) begin
      if (low) begin
        low <= 1'b0;
        cnt <= CW'(HI_CYC - 1);
      end else begin
        active <= 1'b0;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign strobe_n = !(active && low);
  assign sample   = active && low && (cnt == '0);
  assign fin      = active && !low && (cnt == '0);

  // R4: the strobe rises only right after its last low cycle
  p_rise_after_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> $past(sample));

endmodule

// File: rtl/nprd_rdy_wait.sv
module nprd_rdy_wait #(
  parameter int TMO_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rb_n,
  output logic ready,
  output logic timeout
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [1:0]    sync;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b00;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], rb_n};
      if (!en)
        cnt <= '0;
      else if (cnt != TW'(TMO_CYC - 1))
        cnt <= cnt + 1'b1;
    end
  end

  assign ready   = en && sync[1];
  assign timeout = en && !sync[1] && (cnt == TW'(TMO_CYC - 1));

  // R9: a timeout can only follow a wait that was already running
  p_tmo_in_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(en));

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nprd_pkg::*;
#(
  parameter int NCHIP     = 4,
  parameter int CNT_W     = 16,
  parameter int DEF_BYTES = 4314,
  parameter int LO_CYC    = 2,
  parameter int HI_CYC    = 2,
  parameter int PAUSE_CYC = 4,
  parameter int TMO_CYC   = 100000,
  localparam int CHIP_W   = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       page,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [CHIP_W-1:0] chip,
  output logic [NCHIP-1:0]  ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        io_out,
  output logic              io_oe,
  input  logic [7:0]        io_in,
  input  logic              rb_n,
  output logic [7:0]        dout,
  output logic              dout_valid,
  output logic              done,
  output logic              err
);
  localparam int PW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC + 1) : 1;

  nprd_state_t       state;
  logic [2:0]        step;
  logic              second;
  logic [PW-1:0]     pcnt;
  logic [CNT_W-1:0]  left;
  logic [23:0]       pg;
  logic [CHIP_W-1:0] chip_q;
  logic              err_q;

  // named internal events
  logic busy, in_wr, in_rd, in_wait;
  logic str_n, str_sample, str_fin;
  logic w_ready, w_tmo;

  assign busy    = (state != S_IDLE) && (state != S_FIN);
  assign in_wr   = (state == S_WR);
  assign in_rd   = (state == S_RD);
  assign in_wait = (state == S_WAIT);

  nprd_strobe #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) i_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_wr || in_rd),
    .strobe_n(str_n),
    .sample  (str_sample),
    .fin     (str_fin)
  );

  nprd_rdy_wait #(.TMO_CYC(TMO_CYC)) i_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_wait),
    .rb_n   (rb_n),
    .ready  (w_ready),
    .timeout(w_tmo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      step   <= '0;
      second <= 1'b0;
      pcnt   <= '0;
      left   <= '0;
      pg     <= '0;
      chip_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pg     <= page;
          chip_q <= chip;
          left   <= CNT_W'(eff_len(32'(byte_count), 32'(DEF_BYTES)));
          step   <= '0;
          second <= 1'b0;
          err_q  <= 1'b0;
          pcnt   <= PW'(PAUSE_CYC - 1);
          state  <= S_PAUSE;
        end
        S_PAUSE: begin
          if (pcnt == '0) state <= S_WAIT;
          else            pcnt  <= pcnt - 1'b1;
        end
        S_WAIT: begin
          if (w_ready) begin
            state <= second ? S_RD : S_WR;
          end else if (w_tmo) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end
        end
        S_WR: if (str_fin) begin
          if (step == LAST_STEP) begin
            second <= 1'b1;
            pcnt   <= PW'(PAUSE_CYC - 1);
            state  <= S_PAUSE;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_RD: if (str_fin) begin
          if (left == CNT_W'(1)) state <= S_FIN;
          else                   left  <= left - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= in_rd && str_sample;
      if (in_rd && str_sample) dout <= io_in;
    end
  end

  for (genvar g = 0; g < NCHIP; g++) begin : g_ce
    assign ce_n[g] = !(busy && (chip_q == CHIP_W'(g)));
  end

  assign we_n   = in_wr ? str_n : 1'b1;
  assign re_n   = in_rd ? str_n : 1'b1;
  assign cle    = in_wr && step_is_cmd(step);
  assign ale    = in_wr && !step_is_cmd(step);
  assign io_oe  = in_wr;
  assign io_out = in_wr ? step_byte(step, pg) : 8'h00;
  assign done   = (state == S_FIN);
  assign err    = done && err_q;

  // R11
  p_cle_ale_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  p_oe_only_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (cle || ale));
  // R2
  p_one_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  p_ce_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ce_n));
  // R5: no strobe while the ready wait has not been satisfied
  p_quiet_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !w_ready) |=> (we_n && re_n));
  // R6
  p_no_we_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> we_n);
  p_valid_from_re_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(!re_n));
  // R8
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (&ce_n && we_n && re_n));

endmodule

// File: tb/test_nand_page_reader.sv
module test_nand_page_reader;
  localparam int NCH  = 4;
  localparam int LO   = 2;
  localparam int HI   = 1;
  localparam int PAU  = 3;
  localparam int TMO  = 200;
  localparam int DEFB = 4314;

  // {page[23:0], count[15:0], chip[7:0], post_busy[15:0]}
  localparam logic [63:0] VEC [5] = '{
    {24'h000000, 16'd1,  8'd0, 16'd0},
    {24'h123456, 16'd7,  8'd1, 16'd20},
    {24'hABCDEF, 16'd32, 8'd3, 16'd8},
    {24'hFFFFFF, 16'd3,  8'd2, 16'd150},
    {24'h00FF01, 16'd2,  8'd1, 16'd170}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] page = '0;
  logic [15:0] byte_count = '0;
  logic [1:0] chip = '0;
  logic [NCH-1:0] ce_n;
  logic cle, ale, we_n, re_n, io_oe, dout_valid, done, err;
  logic [7:0] io_out, dout;
  logic [7:0] io_in = 8'h00;
  logic rb_n = 1'b1;

  always #5 clk = ~clk;

  nand_page_reader #(
    .NCHIP(NCH), .CNT_W(16), .DEF_BYTES(DEFB), .LO_CYC(LO), .HI_CYC(HI),
    .PAUSE_CYC(PAU), .TMO_CYC(TMO)
  ) i_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .byte_count(byte_count),
    .chip(chip), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n), .dout(dout),
    .dout_valid(dout_valid), .done(done), .err(err)
  );

  function automatic logic [7:0] pat(input logic [23:0] pg, input int idx);
    return pg[7:0] ^ pg[15:8] ^ 8'(idx * 5 + (idx >> 8)) ^ 8'h5A;
  endfunction

  // expected write k as {cle, ale, byte} (R3)
  function automatic logic [9:0] exp_wr(input int k, input logic [23:0] pg);
    case (k)
      0:       return {2'b10, 8'h00};
      3:       return {2'b01, pg[7:0]};
      4:       return {2'b01, pg[15:8]};
      5:       return {2'b01, pg[23:16]};
      6:       return {2'b10, 8'h30};
      default: return {2'b01, 8'h00};
    endcase
  endfunction

  // model configuration (written by the stimulus only)
  logic [23:0] cur_page = '0;
  int cur_chip = 0, post_busy = 0, pre_busy = 0;
  bit stuck_all = 0, stuck_after = 0;
  int rd_base = 0, dout_base = 0;

  // model / monitor state (written by the monitor only)
  logic [9:0] wr_log [64];
  int wr_total = 0, rd_total = 0, dout_total = 0, dout_bad = 0;
  int viol = 0, width_bad = 0, ce_bad = 0, busy_left = 0;
  int we_lo = 0, re_lo = 0, we_hi = 0, re_hi = 0;
  bit we_prev = 1, re_prev = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start) busy_left = pre_busy;
      else if (busy_left > 0) busy_left = busy_left - 1;
      if (we_n && !we_prev) begin
        wr_log[wr_total % 64] = {cle, ale, io_out};
        wr_total = wr_total + 1;
        if (cle && io_out == 8'h30) busy_left = stuck_after ? 32'h3fffffff : post_busy;
      end
      if (!we_n && we_prev && !rb_n) viol = viol + 1;
      if (!re_n && re_prev && !rb_n) viol = viol + 1;
      if (re_n && !re_prev) rd_total = rd_total + 1;
      // strobe widths (R4)
      if (!we_n) we_lo = we_lo + 1;
      else begin if (we_lo != 0 && we_lo != LO) width_bad = width_bad + 1; we_lo = 0; end
      if (!re_n) re_lo = re_lo + 1;
      else begin if (re_lo != 0 && re_lo != LO) width_bad = width_bad + 1; re_lo = 0; end
      if (!we_n && we_prev) begin if (we_hi < HI) width_bad = width_bad + 1; we_hi = 0; end
      else if (we_n) we_hi = we_hi + 1;
      if (!re_n && re_prev) begin if (re_hi < HI) width_bad = width_bad + 1; re_hi = 0; end
      else if (re_n) re_hi = re_hi + 1;
      if (ce_n != '1 && ce_n != ~(NCH'(1) << cur_chip)) ce_bad = ce_bad + 1;
      if (dout_valid) begin
        if (dout != pat(cur_page, dout_total - dout_base)) begin
          dout_bad = dout_bad + 1;
          $display("FAIL R6 byte %0d: actual=%0h expected=%0h", dout_total - dout_base,
                   dout, pat(cur_page, dout_total - dout_base));
        end
        dout_total = dout_total + 1;
      end
      io_in = pat(cur_page, rd_total - rd_base);
      rb_n  = (busy_left == 0) && !stuck_all;
      we_prev = we_n;
      re_prev = re_n;
    end
  end

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic kick(input logic [23:0] pg, input logic [15:0] cnt, input int ch);
    cur_page = pg; cur_chip = ch;
    rd_base = rd_total; dout_base = dout_total;
    @(posedge clk); #2;
    start = 1'b1; page = pg; byte_count = cnt; chip = 2'(ch);
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit, output bit seen, output bit e,
                           output logic [NCH-1:0] ce);
    seen = 0; e = 0; ce = '0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #1;
      if (done) begin seen = 1; e = err; ce = ce_n; break; end
    end
  endtask

  initial begin
    bit seen, e;
    logic [NCH-1:0] ce;
    int w0, r0, d0, b0, v0, wb0, c0, sb;

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(ce_n == '1 && we_n && re_n && !cle && !ale && !done && !dout_valid && !err,
        "R1", "idle outputs", {ce_n, we_n, re_n, cle, ale, done, dout_valid},
        {4'hF, 1'b1, 1'b1, 5'b0});

    // table-driven reads
    for (int v = 0; v < 5; v++) begin
      logic [23:0] pg = VEC[v][63:40];
      logic [15:0] cnt = VEC[v][39:24];
      int ch = int'(VEC[v][23:16]);
      post_busy = int'(VEC[v][15:0]);
      pre_busy = post_busy / 2;
      w0 = wr_total; r0 = rd_total; d0 = dout_total; b0 = dout_bad;
      v0 = viol; wb0 = width_bad; c0 = ce_bad;
      kick(pg, cnt, ch);
      wait_done(2000 + int'(cnt) * 8, seen, e, ce);
      chk(seen && !e, "R8", "done without error", {seen, e}, 2'b10);
      chk(ce == '1, "R8", "chip released at done", ce, 4'hF);
      chk(wr_total - w0 == 7, "R3", "write count", wr_total - w0, 7);
      sb = 0;
      for (int k = 0; k < 7; k++)
        if (wr_log[(w0 + k) % 64] != exp_wr(k, pg)) sb++;
      chk(sb == 0, "R3", "command/address sequence mismatches", sb, 0);
      chk(rd_total - r0 == int'(cnt), "R6", "RE# strobes", rd_total - r0, cnt);
      chk(dout_total - d0 == int'(cnt), "R6", "bytes delivered", dout_total - d0, cnt);
      chk(dout_bad == b0, "R6", "byte value errors", dout_bad - b0, 0);
      chk(width_bad == wb0, "R4", "strobe width errors", width_bad - wb0, 0);
      chk(viol == v0, "R5", "strobes while busy (R2 too)", viol - v0, 0);
      chk(ce_bad == c0, "R2", "wrong chip enable", ce_bad - c0, 0);
    end

    // R7: zero length selects the default
    pre_busy = 0; post_busy = 5;
    d0 = dout_total; b0 = dout_bad;
    kick(24'h000200, 16'd0, 0);
    wait_done(60000, seen, e, ce);
    chk(seen && !e, "R7", "default read completes", {seen, e}, 2'b10);
    chk(dout_total - d0 == DEFB, "R7", "default byte count", dout_total - d0, DEFB);
    chk(dout_bad == b0, "R7", "default read byte errors", dout_bad - b0, 0);

    // R9: stuck busy before the command
    stuck_all = 1;
    w0 = wr_total; r0 = rd_total;
    kick(24'h000010, 16'd4, 2);
    wait_done(TMO + 100, seen, e, ce);
    chk(seen && e, "R9", "timeout before command flags err", {seen, e}, 2'b11);
    chk(wr_total == w0 && rd_total == r0, "R9", "strobes after early timeout",
        (wr_total - w0) + (rd_total - r0), 0);
    chk(ce == '1, "R9", "chip released on timeout", ce, 4'hF);
    stuck_all = 0;
    repeat (5) @(posedge clk);

    // R9: stuck busy after the confirm
    stuck_after = 1;
    w0 = wr_total; r0 = rd_total;
    kick(24'h000011, 16'd4, 1);
    wait_done(TMO + 200, seen, e, ce);
    chk(seen && e, "R9", "timeout after confirm flags err", {seen, e}, 2'b11);
    chk(wr_total - w0 == 7, "R9", "writes before late timeout", wr_total - w0, 7);
    chk(rd_total == r0, "R9", "reads after late timeout", rd_total - r0, 0);
    stuck_after = 0;
    repeat (5) @(posedge clk);

    // R10: start during a read is ignored
    w0 = wr_total; d0 = dout_total;
    kick(24'h0A0B0C, 16'd40, 3);
    repeat (60) @(posedge clk);
    #2 start = 1'b1; page = 24'h777777; byte_count = 16'd5; chip = 2'd0;
    @(posedge clk); #2 start = 1'b0;
    wait_done(2000, seen, e, ce);
    chk(seen && !e, "R10", "first read completes", {seen, e}, 2'b10);
    chk(dout_total - d0 == 40, "R10", "byte count unchanged", dout_total - d0, 40);
    repeat (30) @(negedge clk);
    #1;
    chk(wr_total - w0 == 7 && ce_n == '1, "R10", "no second sequence",
        wr_total - w0, 7);
    chk(width_bad == 0 && viol == 0 && ce_bad == 0, "R11", "bus monitor errors overall",
        width_bad + viol + ce_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule